// File: doc/BRIEF.md
# Double-Buffered DAC Code Bank

This block holds the digital codes for a bank of 8-bit DAC channels: one channel per device pin and one extra channel for a shared pullup supply. Every channel has two registers. The first is an input latch, which a host writes over a small memory-mapped bus. The second is an output latch, which drives the converter. A write to a transfer address copies every input latch into its output latch on the same clock edge. Software can therefore prepare any number of channels and make them take effect together. No channel can be updated on its own.

The bus is synchronous to `clk`. A write is taken on the first clock edge at which the active-low write strobe is seen low after having been high, with the active-low chip enable low at that edge. The bus reset clears only the strobe edge detector. It does not touch any DAC latch. For each pin channel the block also gives a model output: the expected pin voltage in tenths of a volt, derived from the transferred code.

Top module: `dac_bank_dbuf`

## Requirements
- R1: A bus write with `addr[10:4]` = k and `addr[1:0]` = 3 loads pin channel k's input latch, for every k < NUM_PINS (offsets 3, 7, 11 and 15 of the 16-byte window alias). Writes to offsets 0, 1, 2, 4, 5 and 6 of a window leave every latch unchanged.
- R2: A write inside 0x300–0x37F whose low nibble is 5 or 7 loads the supply channel's input latch.
- R3: Loading an input latch leaves all output codes unchanged.
- R4: A write inside 0x300–0x37F whose low nibble is 8–11 copies every input latch, including the supply channel's, to its output. This happens on the clock edge that takes the write. The data on the bus is ignored.
- R5: A channel that was not rewritten since the previous transfer keeps its output code across a transfer.
- R6: `pin_tenths` for a channel equals 0 when its output code is below 5, and code − 5 otherwise (0.1 V per code less 0.5 V, clamped; 250 at code 255).
- R7: A write with `bus_ce_n` high is ignored. A strobe held low for several cycles is taken once, with the data present on its first low cycle.
- R8: Asserting reset leaves every input and output latch unchanged.
- R9: Writes during reset are ignored. A strobe that is already low when reset releases is not taken until it rises and falls again.
- R10: Writes to addresses outside the pin windows and outside the decoded offsets of 0x300–0x37F (for example 0x300, 0x386, 0x7FF) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and latch clock |
| rst_n | input | 1 | Active-low bus reset; clears only the strobe edge detector |
| bus_addr | input | 11 | Byte address |
| bus_data | input | 8 | Write data |
| bus_ce_n | input | 1 | Active-low chip enable |
| bus_wr_n | input | 1 | Active-low write strobe |
| pin_code | output | NUM_PINS*8 | Output-latch codes, channel k at bits [8k+7:8k] |
| supply_code | output | 8 | Output-latch code of the pullup-supply channel |
| pin_tenths | output | NUM_PINS*8 | Modelled pin voltage in 0.1 V units, channel k at [8k+7:8k] |

## Verification
The bench first loads new codes and checks that nothing moves before a transfer. A design without the second latch stage would show each code at once. Partial rewrites followed by a transfer expose any design that clears, or shifts, the channels that were not touched. Aliased offsets, register mirrors, non-DAC offsets and unmapped addresses are each written and then transferred. This catches decoders that are too narrow or too loose. A sweep of all 256 codes checks the clamp below code 5 and the 250 end point. Strobes held low, strobes written with the chip disabled, and strobes held across reset catch designs that are level-sensitive, or that clear the DAC latches on reset.

// File: rtl/dac_bank_dbuf.sv
module dac_bank_dbuf #(
  parameter int NUM_PINS = 16,
  parameter int CODE_W   = 8,
  parameter int ADDR_W   = 11
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [7:0]                 bus_data,
  input  logic                       bus_ce_n,
  input  logic                       bus_wr_n,
  output logic [NUM_PINS*CODE_W-1:0] pin_code,
  output logic [CODE_W-1:0]          supply_code,
  output logic [NUM_PINS*CODE_W-1:0] pin_tenths
);
  localparam int WIN_BITS  = 4;
  localparam int IDX_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
  localparam logic [ADDR_W-1:0] PIN_SPAN = ADDR_W'(NUM_PINS << WIN_BITS);
  localparam logic [ADDR_W-8:0] ANA_PAGE = (ADDR_W-7)'(6);

  logic wr_q;
  logic wr_stb, in_ana, pin_hit, sup_hit, xfer_hit;
  logic [IDX_W-1:0] pin_idx;
  logic [NUM_PINS-1:0][CODE_W-1:0] pin_in, pin_out;
  logic [CODE_W-1:0] sup_in, sup_out;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= bus_wr_n;

  assign wr_stb   = wr_q & ~bus_wr_n & ~bus_ce_n;
  assign in_ana   = bus_addr[ADDR_W-1:7] == ANA_PAGE;
  assign pin_hit  = wr_stb & (bus_addr < PIN_SPAN) & (bus_addr[1:0] == 2'b11);
  assign pin_idx  = bus_addr[WIN_BITS +: IDX_W];
  assign sup_hit  = wr_stb & in_ana & ~bus_addr[3] & bus_addr[2] & bus_addr[0];
  assign xfer_hit = wr_stb & in_ana & (bus_addr[3:2] == 2'b10);

  always_ff @(posedge clk) begin
    if (sup_hit)  sup_in  <= bus_data[CODE_W-1:0];
    if (xfer_hit) sup_out <= sup_in;
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_chan
    always_ff @(posedge clk) begin
      if (pin_hit && pin_idx == IDX_W'(i)) pin_in[i] <= bus_data[CODE_W-1:0];
      if (xfer_hit) pin_out[i] <= pin_in[i];
    end
    assign pin_code[i*CODE_W +: CODE_W]   = pin_out[i];
    assign pin_tenths[i*CODE_W +: CODE_W] = (pin_out[i] < CODE_W'(5)) ? '0 : pin_out[i] - CODE_W'(5);
  end

  assign supply_code = sup_out;
endmodule

module dac_bank_dbuf_chk #(
  parameter int NUM_PINS = 16,
  parameter int CODE_W   = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       bus_ce_n,
  input logic                       wr_stb,
  input logic                       xfer_hit,
  input logic [NUM_PINS*CODE_W-1:0] pin_in,
  input logic [CODE_W-1:0]          sup_in,
  input logic [NUM_PINS*CODE_W-1:0] pin_code,
  input logic [CODE_W-1:0]          supply_code,
  input logic [NUM_PINS*CODE_W-1:0] pin_tenths
);
  logic seen_clk = 1'b0;
  always_ff @(posedge clk) seen_clk <= 1'b1;

  assert_xfer_copies_R4: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_hit |=> (pin_code == $past(pin_in)) && (supply_code == $past(sup_in)));

  assert_hold_without_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer_hit |=> $stable(pin_code) && $stable(supply_code));

  assert_reset_keeps_codes_R8: assert property (@(posedge clk)
    (seen_clk && !rst_n) |=> $stable(pin_code) && $stable(supply_code));

  assert_no_strobe_in_reset_R9: assert property (@(posedge clk)
    (seen_clk && !rst_n) |-> !wr_stb);

  assert_ce_gates_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ce_n |-> !wr_stb);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_model
    assert_clamp_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_code[i*CODE_W +: CODE_W] < CODE_W'(5)) |-> pin_tenths[i*CODE_W +: CODE_W] == '0);
    assert_tenths_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pin_tenths[i*CODE_W +: CODE_W] <= CODE_W'(250));
  end
endmodule

bind dac_bank_dbuf dac_bank_dbuf_chk #(.NUM_PINS(NUM_PINS), .CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_ce_n(bus_ce_n), .wr_stb(wr_stb), .xfer_hit(xfer_hit),
  .pin_in(pin_in), .sup_in(sup_in), .pin_code(pin_code), .supply_code(supply_code),
  .pin_tenths(pin_tenths)
);

// File: tb/dac_bank_dbuf_tb.sv
module dac_bank_dbuf_tb_top;
  localparam int NP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [10:0] bus_addr = '0;
  logic [7:0]  bus_data = '0;
  logic bus_ce_n = 1'b1;
  logic bus_wr_n = 1'b1;
  logic [NP*8-1:0] pin_code, pin_tenths;
  logic [7:0] supply_code;

  int checks = 0;
  int failures = 0;
  int exp_in  [NP];
  int exp_out [NP];
  int exp_sup_in = 0;
  int exp_sup_out = 0;

  always #2.5 clk = ~clk;

  dac_bank_dbuf #(.NUM_PINS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
    .bus_ce_n(bus_ce_n), .bus_wr_n(bus_wr_n), .pin_code(pin_code),
    .supply_code(supply_code), .pin_tenths(pin_tenths)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic void model(input int a, input int d);
    if (a < NP*16 && (a & 3) == 3) exp_in[a >> 4] = d;
    else if (a >= 'h300 && a < 'h380) begin
      if ((a & 15) == 5 || (a & 15) == 7) exp_sup_in = d;
      else if ((a & 15) >= 8 && (a & 15) <= 11) begin
        for (int k = 0; k < NP; k++) exp_out[k] = exp_in[k];
        exp_sup_out = exp_sup_in;
      end
    end
  endfunction

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 11'(a); bus_data = 8'(d); bus_ce_n = 1'b0; bus_wr_n = 1'b0;
    @(negedge clk);
    bus_wr_n = 1'b1; bus_ce_n = 1'b1;
    model(a, d);
  endtask

  task automatic check_all(input string req);
    @(negedge clk);
    for (int k = 0; k < NP; k++) begin
      chk(req, $sformatf("pin%0d code", k), int'(pin_code[k*8 +: 8]), exp_out[k]);
      chk(req, $sformatf("pin%0d tenths", k), int'(pin_tenths[k*8 +: 8]),
          exp_out[k] < 5 ? 0 : exp_out[k] - 5);
    end
    chk(req, "supply code", int'(supply_code), exp_sup_out);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int k = 0; k < NP; k++) begin exp_in[k] = 0; exp_out[k] = 0; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // initialise every channel to 0 and transfer: baseline state (R1 R2 R4)
    for (int k = 0; k < NP; k++) wr(k*16 + 3, 0);
    wr('h305, 0);
    wr('h308, 'h5A);
    check_all("R4 baseline");

    // R1 R3: load all pins and supply, outputs must not move
    for (int k = 0; k < NP; k++) wr(k*16 + 3, 10 + 7*k);
    wr('h305, 'hC3);
    check_all("R3");
    // R4: transfer at 308h, data ignored
    wr('h308, 'hFF);
    check_all("R4");

    // R5: rewrite pin 2 and supply via 307h mirror, transfer at 30Bh
    wr(2*16 + 3, 200);
    wr('h307, 'h11);
    wr('h30B, 0);
    check_all("R5");

    // R1 aliases 7/B/F, R2 mirror 315h, R4 mirror 31Ah
    wr(4*16 + 7, 33);
    wr(5*16 + 11, 44);
    wr(NP*16 - 1, 255);
    wr('h315, 'h77);
    wr('h31A, 'h00);
    check_all("R1 R2 alias");

    // R1 R10: non-DAC offsets and unmapped addresses change nothing
    for (int o = 0; o < 3; o++) wr(6*16 + o, 99);
    wr(6*16 + 4, 98); wr(6*16 + 5, 97); wr(6*16 + 6, 96);
    wr('h300, 1); wr('h301, 2); wr('h30C, 3); wr('h386, 4); wr('h38B, 5);
    wr(NP*16 + 3, 6); wr('h7FF, 7); wr('h403, 8);
    wr('h309, 0);
    check_all("R10");

    // R7: chip disabled write ignored
    @(negedge clk);
    bus_addr = 11'(1*16 + 3); bus_data = 8'd150; bus_ce_n = 1'b1; bus_wr_n = 1'b0;
    @(negedge clk); bus_wr_n = 1'b1;
    wr('h308, 0);
    check_all("R7 ce_n");

    // R7: strobe held low, data changes; only first captured
    @(negedge clk);
    bus_addr = 11'(3*16 + 3); bus_data = 8'd61; bus_ce_n = 1'b0; bus_wr_n = 1'b0;
    @(negedge clk); bus_data = 8'd190;
    @(negedge clk); @(negedge clk);
    bus_wr_n = 1'b1; bus_ce_n = 1'b1;
    model(3*16 + 3, 61);
    wr('h308, 0);
    check_all("R7 held");

    // R8: reset leaves latches; R9: writes in reset and strobe held through release ignored
    wr(7*16 + 3, 123);
    @(negedge clk); rst_n = 1'b0;
    check_all("R8 during reset");
    @(negedge clk);
    bus_addr = 11'h308; bus_ce_n = 1'b0; bus_wr_n = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check_all("R9 held strobe");
    bus_wr_n = 1'b1; bus_ce_n = 1'b1;
    wr('h308, 0);
    check_all("R8 input latch kept");

    // R6: exhaustive code sweep on first and last pin
    for (int c = 0; c < 256; c++) begin
      wr(3, c);
      wr((NP-1)*16 + 3, 255 - c);
      wr('h30A, c);
      @(negedge clk);
      chk("R6", $sformatf("code %0d tenths", c), int'(pin_tenths[7:0]), c < 5 ? 0 : c - 5);
      chk("R6", $sformatf("code %0d tenths", 255 - c), int'(pin_tenths[(NP-1)*8 +: 8]),
          (255 - c) < 5 ? 0 : 250 - c);
      chk("R4", "sweep code", int'(pin_code[7:0]), c);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule